// File: doc/BRIEF.md
# Carry-Select Binary Adder

This block adds two unsigned N-bit operands and a carry-in, and returns an N-bit sum with a carry-out, using purely combinational logic. The word is cut into a lower and an upper half. The lower half is summed by a ripple chain driven by the external carry-in. In parallel, the upper half is summed twice: one copy assumes that no carry arrives, and the other assumes that a carry does arrive. When the real carry leaves the lower half, a 2:1 selector picks the matching upper sum. This takes the upper ripple off the critical path.

The final carry-out is built as (upper carry with assumed 0 OR lower carry) AND (upper carry with assumed 1). In this form the late-arriving lower carry passes through only one gate pair. The form is equal to the more familiar OR-of-AND form, because an upper half that carries out with an assumed carry-in of 0 always carries out with an assumed carry-in of 1.

A parameter can make the same split repeat inside each half until a leaf width is reached. The depth then grows with log N rather than with N. The block has no clock and no reset. It is meant to sit inside a larger datapath stage.

Top module: `csa_adder`

## Requirements
- R1: For every operand pair and both carry-in values, {cout, sum} equals a + b + cin taken as an (N+1)-bit unsigned sum. This holds at the default N = 8 with the flat structure.
- R2: The lower N/2 bits of sum equal the low N/2 bits of a[N/2-1:0] + b[N/2-1:0] + cin. They do not depend on the upper operand bits.
- R3: cout equals Chi0 | (Clo & Chi1). Chi0 and Chi1 are the carries out of the upper-half sum a_hi + b_hi with an assumed carry-in of 0 and of 1. Clo is the carry out of the lower half. Chi0 = 1 always implies Chi1 = 1.
- R4: The upper N/2 bits of sum equal the low N/2 bits of a_hi + b_hi + Clo. So, when the upper operand halves sum to all ones, the upper sum bits depend on the lower carry alone.
- R5: With RECURSIVE = 1 the same split repeats inside each half down to LEAF_W bits, and R1 still holds. This is checked at N = 8 with LEAF_W = 2 and at N = 32 with LEAF_W = 4.
- R6: A carry that enters at cin ripples through a full word of ones. a = all ones, b = 0, cin = 1 gives sum = 0 and cout = 1. a = all ones, b = 0, cin = 0 gives sum = all ones and cout = 0.
- R7: The outputs depend only on the present inputs. A change on any input shows up at sum and cout with no clock edge in between.
- R8: N must be even and at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The block holds no state, so a fault in its internal carries shows at the ports as soon as the inputs settle. A wrong lower carry flips the whole upper half of sum at once. A wrong upper carry, with an assumed carry-in of either 0 or 1, corrupts only cout. That second fault can be seen only on inputs where the upper operand half sums to all ones, or where it generates a carry. The directed cases therefore aim at these propagate and generate patterns of the upper half, with the lower carry both set and clear. The exhaustive and random sweeps then cover every other combination.

// File: rtl/csa_pkg.sv
// Package: shared helpers for the carry-select adder.
// Holds the carry-merge function, so that the top level and every
// recursive stage form their carry-out the same way.
package csa_pkg;

    // Merge the two speculative upper carries with the real lower carry.
    // The late lower carry sits on the short path: OR first, then AND.
    function automatic logic csa_carry_merge(
        input logic hi_c0,
        input logic lo_c,
        input logic hi_c1
    );
        return (hi_c0 | lo_c) & hi_c1;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
// Module: csa_ripple
// Plain ripple-carry adder of W bits. It is the leaf of the carry-select tree.
// Assumes: W >= 1. Purely combinational.
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    // Walk the carry from bit 0 upward, one full adder per bit.
    always_comb begin
        logic cy;
        cy = cin;
        for (int i = 0; i < W; i++) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
        end
        cout = cy;
    end

endmodule

// File: rtl/csa_sel.sv
// Module: csa_sel
// 2:1 selector for one speculative upper-half sum.
// Assumes: pick arrives late. It is the real carry from the lower half.
module csa_sel #(
    parameter int W = 4
) (
    input  logic [W-1:0] sum_c0,
    input  logic [W-1:0] sum_c1,
    input  logic         pick,
    output logic [W-1:0] sum_out
);

    // Choose the upper sum that matches the real incoming carry.
    always_comb begin
        sum_out = pick ? sum_c1 : sum_c0;
    end

endmodule

// File: rtl/csa_stage.sv
// Module: csa_stage
// One adder of W bits. It is a ripple leaf when recursion is off, or when W
// has reached LEAF_W. Otherwise it is a carry-select split whose halves are
// csa_stage instances again.
// Assumes: W >= 1 and LEAF_W >= 1. An odd W is split as floor/ceil.
module csa_stage #(
    parameter int W         = 4,
    parameter bit RECURSIVE = 1'b0,
    parameter int LEAF_W    = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import csa_pkg::*;

    localparam int  LO_W    = W / 2;
    localparam int  HI_W    = W - LO_W;
    localparam bit  IS_LEAF = (!RECURSIVE) || (W <= LEAF_W) || (W < 2);

    generate
        if (IS_LEAF) begin : g_leaf
            csa_ripple #(.W(W)) rip_i (
                .a   (a),
                .b   (b),
                .cin (cin),
                .sum (sum),
                .cout(cout)
            );
        end else begin : g_split
            logic [LO_W-1:0] lo_sum;
            logic            lo_c;
            logic [HI_W-1:0] hs0, hs1, hsel;
            logic            hc0, hc1;

            csa_stage #(.W(LO_W), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) lo_i (
                .a   (a[LO_W-1:0]),
                .b   (b[LO_W-1:0]),
                .cin (cin),
                .sum (lo_sum),
                .cout(lo_c)
            );
            csa_stage #(.W(HI_W), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) hi0_i (
                .a   (a[W-1:LO_W]),
                .b   (b[W-1:LO_W]),
                .cin (1'b0),
                .sum (hs0),
                .cout(hc0)
            );
            csa_stage #(.W(HI_W), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) hi1_i (
                .a   (a[W-1:LO_W]),
                .b   (b[W-1:LO_W]),
                .cin (1'b1),
                .sum (hs1),
                .cout(hc1)
            );
            csa_sel #(.W(HI_W)) sel_i (
                .sum_c0 (hs0),
                .sum_c1 (hs1),
                .pick   (lo_c),
                .sum_out(hsel)
            );

            // Put the halves together and merge the carries.
            always_comb begin
                sum  = {hsel, lo_sum};
                cout = csa_carry_merge(hc0, lo_c, hc1);
            end
        end
    endgenerate

endmodule

// File: rtl/csa_adder.sv
// Module: csa_adder (top)
// Carry-select adder of N bits: {cout, sum} = a + b + cin.
// The lower half ripples from cin. The upper half is summed for both
// possible carries, and the real lower carry selects the result. With
// RECURSIVE set, every half repeats the split down to LEAF_W bits.
// Assumes: N even and N >= 2. No clock, no reset.
module csa_adder #(
    parameter int N         = 8,
    parameter bit RECURSIVE = 1'b0,
    parameter int LEAF_W    = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    import csa_pkg::*;

    localparam int H = N / 2;

    // Stop elaboration on a width the split cannot take (R8).
    generate
        if ((N < 2) || ((N % 2) != 0)) begin : g_bad_width
            $error("csa_adder: N must be even and at least 2");
        end
    endgenerate

    logic [H-1:0] lo_sum;
    logic         lo_carry;
    logic [H-1:0] hi_sum0, hi_sum1, hi_sum;
    logic         hi_c0, hi_c1;

    csa_stage #(.W(H), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) lo_i (
        .a   (a[H-1:0]),
        .b   (b[H-1:0]),
        .cin (cin),
        .sum (lo_sum),
        .cout(lo_carry)
    );
    csa_stage #(.W(H), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) hi0_i (
        .a   (a[N-1:H]),
        .b   (b[N-1:H]),
        .cin (1'b0),
        .sum (hi_sum0),
        .cout(hi_c0)
    );
    csa_stage #(.W(H), .RECURSIVE(RECURSIVE), .LEAF_W(LEAF_W)) hi1_i (
        .a   (a[N-1:H]),
        .b   (b[N-1:H]),
        .cin (1'b1),
        .sum (hi_sum1),
        .cout(hi_c1)
    );
    csa_sel #(.W(H)) sel_i (
        .sum_c0 (hi_sum0),
        .sum_c1 (hi_sum1),
        .pick   (lo_carry),
        .sum_out(hi_sum)
    );

    // Drive the outputs from the selected upper sum and the merged carry.
    always_comb begin
        sum  = {hi_sum, lo_sum};
        cout = csa_carry_merge(hi_c0, lo_carry, hi_c1);
    end

endmodule

// File: rtl/csa_adder_chk.sv
// Module: csa_adder_chk
// Checker bound to csa_adder. Relates the ports to the speculative
// upper-half results at the first split.
// Assumes: it is sampled after the combinational logic has settled.
module csa_adder_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic           cin,
    input logic [N-1:0]   sum,
    input logic           cout,
    input logic           lo_carry,
    input logic           hi_c0,
    input logic           hi_c1,
    input logic [N/2-1:0] hi_sum0,
    input logic [N/2-1:0] hi_sum1
);
    localparam int H = N / 2;

    // Check the settled port and internal relations each time they change.
    always_comb begin
        p_sum_exact_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
            else $error("R1 sum mismatch");
        p_low_half_r2: assert (sum[H-1:0] == H'(a[H-1:0] + b[H-1:0] + {{(H-1){1'b0}}, cin}))
            else $error("R2 low half mismatch");
        p_hi_carry_order_r3: assert (!hi_c0 || hi_c1)
            else $error("R3 carry order broken");
        p_cout_alt_form_r3: assert (cout == (hi_c0 | (lo_carry & hi_c1)))
            else $error("R3 carry-out form mismatch");
        p_hi_spec_pair_r4: assert ({hi_c1, hi_sum1} == ({hi_c0, hi_sum0} + (H + 1)'(1)))
            else $error("R4 speculative sums differ by more than one");
    end

endmodule

bind csa_adder csa_adder_chk #(.N(N)) chk_i (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .lo_carry(lo_carry),
    .hi_c0   (hi_c0),
    .hi_c1   (hi_c1),
    .hi_sum0 (hi_sum0),
    .hi_sum1 (hi_sum1)
);

// File: tb/csa_adder_tb.sv
// Bench: csa_adder_tb_top
// Sweeps every input at N = 8 for the flat and the recursive build. Runs
// directed and random vectors at N = 32 recursive. All expected values
// come from bench functions.
module csa_adder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;
    localparam int RAND_VECS  = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    // Free-running bench clock.
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [7:0]  a8, b8, s8f, s8r;
    logic        c8, co8f, co8r;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    csa_adder #(.N(8), .RECURSIVE(1'b0), .LEAF_W(4)) dut_i (
        .a(a8), .b(b8), .cin(c8), .sum(s8f), .cout(co8f)
    );
    csa_adder #(.N(8), .RECURSIVE(1'b1), .LEAF_W(2)) dut_rec8_i (
        .a(a8), .b(b8), .cin(c8), .sum(s8r), .cout(co8r)
    );
    csa_adder #(.N(32), .RECURSIVE(1'b1), .LEAF_W(4)) dut_rec32_i (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32)
    );

    // Reference full sum of two 8-bit operands and a carry.
    function automatic logic [8:0] ref8(input logic [7:0] x, input logic [7:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {8'd0, c};
    endfunction

    // Reference full sum of two 32-bit operands and a carry.
    function automatic logic [32:0] ref32(input logic [31:0] x, input logic [31:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    // Carry-out built from the half carries, computed arithmetically (R3).
    function automatic logic ref_cout8(input logic [7:0] x, input logic [7:0] y, input logic c);
        logic [4:0] lo, h0, h1;
        lo = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'd0, c};
        h0 = {1'b0, x[7:4]} + {1'b0, y[7:4]};
        h1 = {1'b0, x[7:4]} + {1'b0, y[7:4]} + 5'd1;
        return h0[4] | (lo[4] & h1[4]);
    endfunction

    // Compare one value and log a failure line when it differs.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive an 8-bit vector and wait to the middle of the period.
    task automatic drive8(input logic [7:0] x, input logic [7:0] y, input logic c);
        a8 = x; b8 = y; c8 = c;
        #(CLK_PERIOD / 2);
    endtask

    // End the run as a failure if it hangs.
    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc >= WDOG_LIMIT) begin
                n_errors++;
                $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
                $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
                $finish;
            end
        end
    end

    // Main stimulus sequence.
    initial begin
        void'($urandom(32'd20240611));
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Zero inputs give a zero result.
        drive8(8'h00, 8'h00, 1'b0);
        check("R1 zero", {55'd0, co8f, s8f}, 64'd0);

        // R6: a carry ripples through a full word of ones.
        drive8(8'hFF, 8'h00, 1'b1);
        check("R6 ones+cin", {55'd0, co8f, s8f}, {55'd0, 1'b1, 8'h00});
        check("R6 ones+cin rec", {55'd0, co8r, s8r}, {55'd0, 1'b1, 8'h00});
        drive8(8'hFF, 8'h00, 1'b0);
        check("R6 ones no cin", {55'd0, co8f, s8f}, {55'd0, 1'b0, 8'hFF});

        // R3/R4: upper half propagates, lower carry set, then clear.
        drive8(8'h7F, 8'h81, 1'b0);
        check("R3 propagate clo=1", {63'd0, co8f}, 64'd1);
        check("R4 upper from clo=1", {60'd0, s8f[7:4]}, {60'd0, 4'h0});
        drive8(8'h70, 8'h80, 1'b0);
        check("R3 propagate clo=0", {63'd0, co8f}, 64'd0);
        check("R4 upper from clo=0", {60'd0, s8f[7:4]}, {60'd0, 4'hF});
        // Upper half generates a carry on its own.
        drive8(8'h80, 8'h80, 1'b0);
        check("R3 generate", {63'd0, co8f}, 64'd1);

        // R2: the low half ignores the upper operand bits.
        drive8(8'hA5, 8'h3C, 1'b1);
        check("R2 low half", {60'd0, s8f[3:0]}, {60'd0, 4'h2});
        drive8(8'h55, 8'hCC, 1'b1);
        check("R2 low half other hi", {60'd0, s8f[3:0]}, {60'd0, 4'h2});

        // R7: the outputs follow the inputs with no clock edge in between.
        @(posedge clk);
        #1;
        a8 = 8'd13; b8 = 8'd10; c8 = 1'b0;
        #1;
        check("R7 no-edge update", {55'd0, co8f, s8f}, 64'd23);
        a8 = 8'd31; b8 = 8'd12;
        #1;
        check("R7 second update", {55'd0, co8f, s8f}, 64'd43);
        @(negedge clk);

        // R1/R3/R5: exhaustive sweep at N = 8, flat and recursive.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int k = 0; k < 2; k++) begin
                    a8 = i[7:0]; b8 = j[7:0]; c8 = k[0];
                    #(CLK_PERIOD / 2);
                    check("R1 exhaustive flat", {55'd0, co8f, s8f}, {55'd0, ref8(a8, b8, c8)});
                    check("R5 exhaustive rec8", {55'd0, co8r, s8r}, {55'd0, ref8(a8, b8, c8)});
                    if (co8f !== ref_cout8(a8, b8, c8))
                        check("R3 cout form", {63'd0, co8f}, {63'd0, ref_cout8(a8, b8, c8)});
                end
            end
        end

        // R5: recursive build at N = 32, directed corners.
        a32 = 32'hFFFF_FFFF; b32 = 32'd0; c32 = 1'b1;
        #(CLK_PERIOD / 2);
        check("R5 r32 full ripple", {31'd0, co32, s32}, {31'd0, 33'h1_0000_0000});
        a32 = 32'h8000_0000; b32 = 32'h8000_0000; c32 = 1'b0;
        #(CLK_PERIOD / 2);
        check("R5 r32 top carry", {31'd0, co32, s32}, {31'd0, 33'h1_0000_0000});
        a32 = 32'h0000_FFFF; b32 = 32'h0000_0001; c32 = 1'b0;
        #(CLK_PERIOD / 2);
        check("R5 r32 mid carry", {31'd0, co32, s32}, {31'd0, 33'h0_0001_0000});

        // R5: random vectors at N = 32.
        for (int v = 0; v < RAND_VECS; v++) begin
            a32 = $urandom; b32 = $urandom; c32 = $urandom_range(1, 0);
            #(CLK_PERIOD / 2);
            check("R5 r32 random", {31'd0, co32, s32}, {31'd0, ref32(a32, b32, c32)});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule